// File: doc/BRIEF.md
# Sticky Status Event Register with Summary Mask

This block collects single-cycle event pulses into a register of sticky flags. Once a flag is set it stays set until the host reads the register or issues a global clear. A host-written enable mask selects which flags feed one summary output. A status-reporting hierarchy uses that output as a single "something needs attention" bit.

The host can write the mask, read the mask back, and read the flag register. Reading the flag register returns its contents and clears it on the same clock edge. A flag pulse that arrives in the same cycle as a clearing read or a global clear is still recorded, so no event is lost. The width is a parameter. The block is used at 8 bits for a primary event register and at 16 bits for secondary status registers.

Top module: `evreg_top`

## Requirements
- R1: After synchronous reset, `ev_rdata`, `en_rdata` and `summary` are all zero.
- R2: A high bit on `evt_in` sets the matching bit of `ev_rdata` at the next clock edge. With no read and no clear, that bit stays set for any number of later cycles.
- R3: While `ev_rd` is high, `ev_rdata` shows the current flag contents. At the following edge all flags that were set are cleared.
- R4: If `evt_in` has a bit high in the same cycle as `ev_rd`, the read still returns the earlier contents. After the edge, exactly the new bits are set.
- R5: A high `clr_all` clears all flags at the next edge, except bits pulsed on `evt_in` in that same cycle, which end up set.
- R6: `en_rdata` changes only on a cycle with `en_wr` high. Reset sets it to zero, and neither `clr_all` nor `ev_rd` changes it.
- R7: With `en_wr` high, `en_wdata` is loaded into the enable mask at the next edge, and `en_rdata` shows the loaded value.
- R8: `summary` is registered. After each edge it equals the OR over all bits of (flag AND enable) as they stand after that same edge. A set flag whose enable bit is zero never raises it.
- R9: The same behaviour holds when `WIDTH` is 16, including bit 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_in | input | WIDTH | Event pulses, one bit per flag |
| clr_all | input | 1 | Global clear of all flags |
| en_wr | input | 1 | Enable-mask write strobe |
| en_wdata | input | WIDTH | Enable-mask write value |
| en_rdata | output | WIDTH | Enable-mask readback |
| ev_rd | input | 1 | Destructive read of the flag register |
| ev_rdata | output | WIDTH | Current flag contents |
| summary | output | 1 | Registered masked OR of the flags |

## Verification
The hardest case to reach is a new event pulse landing in exactly the cycle of a clearing read or a global clear. A wrong priority there silently drops an event. The bench first sets a known flag, then drives a different event bit together with the read strobe, and then with the clear strobe. Each time it checks the value returned during the read, and that only the new bit survives the edge. It also moves the mask across set and unset flags, so that the summary is seen to rise and fall on the enable path alone.

// File: rtl/evreg_pkg.sv
package evreg_pkg;

    typedef struct packed {
        logic global_clr;
        logic read_clr;
    } clr_req_t;

    typedef struct packed {
        logic load;
    } mask_req_t;

    function automatic logic clear_active(input clr_req_t req);
        return req.global_clr | req.read_clr;
    endfunction

endpackage

// File: rtl/evreg_flags.sv
module evreg_flags
    import evreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pulse,
    input  clr_req_t         clr_req,
    output logic [WIDTH-1:0] flags_q,
    output logic [WIDTH-1:0] flags_nxt
);

    logic wipe;
    assign wipe = clear_active(clr_req);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Pulse has priority over clear so a colliding event is kept
        always_comb begin
            if (pulse[i])
                flags_nxt[i] = 1'b1;
            else if (wipe)
                flags_nxt[i] = 1'b0;
            else
                flags_nxt[i] = flags_q[i];
        end

        always_ff @(posedge clk) begin
            if (rst)
                flags_q[i] <= 1'b0;
            else
                flags_q[i] <= flags_nxt[i];
        end
    end

endmodule

// File: rtl/evreg_mask.sv
module evreg_mask
    import evreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  mask_req_t        req,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] mask_q,
    output logic [WIDTH-1:0] mask_nxt
);

    assign mask_nxt = req.load ? wdata : mask_q;

    always_ff @(posedge clk) begin
        if (rst)
            mask_q <= '0;
        else
            mask_q <= mask_nxt;
    end

endmodule

// File: rtl/evreg_summary.sv
module evreg_summary #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] flags_nxt,
    input  logic [WIDTH-1:0] mask_nxt,
    output logic             sum_q
);

    logic [WIDTH-1:0] hits;
    assign hits = flags_nxt & mask_nxt;

    always_ff @(posedge clk) begin
        if (rst)
            sum_q <= 1'b0;
        else
            sum_q <= |hits;
    end

endmodule

// File: rtl/evreg_top.sv
module evreg_top
    import evreg_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] evt_in,
    input  logic             clr_all,
    input  logic             en_wr,
    input  logic [WIDTH-1:0] en_wdata,
    output logic [WIDTH-1:0] en_rdata,
    input  logic             ev_rd,
    output logic [WIDTH-1:0] ev_rdata,
    output logic             summary
);

    clr_req_t         clr_req;
    mask_req_t        mask_req;
    logic [WIDTH-1:0] flags_nxt;
    logic [WIDTH-1:0] mask_nxt;

    assign clr_req.global_clr = clr_all;
    assign clr_req.read_clr   = ev_rd;
    assign mask_req.load      = en_wr;

    evreg_flags #(.WIDTH(WIDTH)) u_flags (
        .clk       (clk),
        .rst       (rst),
        .pulse     (evt_in),
        .clr_req   (clr_req),
        .flags_q   (ev_rdata),
        .flags_nxt (flags_nxt)
    );

    evreg_mask #(.WIDTH(WIDTH)) u_mask (
        .clk      (clk),
        .rst      (rst),
        .req      (mask_req),
        .wdata    (en_wdata),
        .mask_q   (en_rdata),
        .mask_nxt (mask_nxt)
    );

    evreg_summary #(.WIDTH(WIDTH)) u_sum (
        .clk       (clk),
        .rst       (rst),
        .flags_nxt (flags_nxt),
        .mask_nxt  (mask_nxt),
        .sum_q     (summary)
    );

endmodule

// File: rtl/evreg_checker.sv
module evreg_checker #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic [WIDTH-1:0] evt_in,
    input logic             clr_all,
    input logic             en_wr,
    input logic [WIDTH-1:0] en_wdata,
    input logic [WIDTH-1:0] en_rdata,
    input logic             ev_rd,
    input logic [WIDTH-1:0] ev_rdata,
    input logic             summary
);

    AST_SUMMARY_MATCH: assert property (@(posedge clk) disable iff (rst)
        summary == |(ev_rdata & en_rdata)); // R8

    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (rst)
        (!ev_rd && !clr_all) |=> ((ev_rdata & $past(ev_rdata)) == $past(ev_rdata))); // R2

    AST_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        (|evt_in) |=> ((ev_rdata & $past(evt_in)) == $past(evt_in))); // R4

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ev_rd && evt_in == '0) |=> (ev_rdata == '0)); // R3

    AST_GLOBAL_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr_all && evt_in == '0) |=> (ev_rdata == '0)); // R5

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !en_wr |=> $stable(en_rdata)); // R6

    AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
        en_wr |=> (en_rdata == $past(en_wdata))); // R7

endmodule

bind evreg_top evreg_checker #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/evreg_top_test.sv
module evreg_top_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  evt_in = '0;
    logic        clr_all = 1'b0;
    logic        en_wr = 1'b0;
    logic [7:0]  en_wdata = '0;
    logic [7:0]  en_rdata;
    logic        ev_rd = 1'b0;
    logic [7:0]  ev_rdata;
    logic        summary;

    logic [15:0] w_evt = '0;
    logic        w_clr = 1'b0;
    logic        w_enwr = 1'b0;
    logic [15:0] w_enwd = '0;
    logic [15:0] w_enrd;
    logic        w_rd = 1'b0;
    logic [15:0] w_evrd;
    logic        w_sum;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    evreg_top #(.WIDTH(8)) uut (
        .clk(clk), .rst(rst), .evt_in(evt_in), .clr_all(clr_all),
        .en_wr(en_wr), .en_wdata(en_wdata), .en_rdata(en_rdata),
        .ev_rd(ev_rd), .ev_rdata(ev_rdata), .summary(summary)
    );

    evreg_top #(.WIDTH(16)) uut_w16 (
        .clk(clk), .rst(rst), .evt_in(w_evt), .clr_all(w_clr),
        .en_wr(w_enwr), .en_wdata(w_enwd), .en_rdata(w_enrd),
        .ev_rd(w_rd), .ev_rdata(w_evrd), .summary(w_sum)
    );

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // inputs change after a falling edge, outputs are sampled at the next falling edge
    task automatic tick();
        @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1", "flags", 16'(ev_rdata), 16'h0);
        check("R1", "mask", 16'(en_rdata), 16'h0);
        check("R1", "summary", 16'(summary), 16'h0);
    endtask

    task automatic t_sticky();
        evt_in = 8'h05; tick(); evt_in = '0;
        check("R2", "set", 16'(ev_rdata), 16'h05);
        repeat (3) tick();
        check("R2", "held", 16'(ev_rdata), 16'h05);
        evt_in = 8'h10; tick(); evt_in = '0;
        check("R2", "accumulate", 16'(ev_rdata), 16'h15);
        check("R8", "masked off", 16'(summary), 16'h0);
    endtask

    task automatic t_enable();
        en_wr = 1'b1; en_wdata = 8'h10; tick(); en_wr = 1'b0;
        check("R7", "mask load", 16'(en_rdata), 16'h10);
        check("R8", "summary up", 16'(summary), 16'h1);
        en_wr = 1'b1; en_wdata = 8'h02; tick(); en_wr = 1'b0;
        check("R8", "unset bit enabled", 16'(summary), 16'h0);
        en_wr = 1'b1; en_wdata = 8'h04; tick(); en_wr = 1'b0;
        check("R7", "mask reload", 16'(en_rdata), 16'h04);
        check("R8", "summary again", 16'(summary), 16'h1);
    endtask

    task automatic t_read_clear();
        ev_rd = 1'b1;
        #1 check("R3", "read value", 16'(ev_rdata), 16'h15);
        tick(); ev_rd = 1'b0;
        check("R3", "cleared", 16'(ev_rdata), 16'h0);
        check("R8", "summary drop", 16'(summary), 16'h0);
        check("R6", "mask after read", 16'(en_rdata), 16'h04);
    endtask

    task automatic t_collide();
        evt_in = 8'h01; tick(); evt_in = '0;
        ev_rd = 1'b1; evt_in = 8'h80;
        #1 check("R4", "old value read", 16'(ev_rdata), 16'h01);
        tick(); ev_rd = 1'b0; evt_in = '0;
        check("R4", "new kept", 16'(ev_rdata), 16'h80);
    endtask

    task automatic t_clear();
        evt_in = 8'h04; tick(); evt_in = '0;
        check("R2", "pre clear", 16'(ev_rdata), 16'h84);
        check("R8", "pre clear summary", 16'(summary), 16'h1);
        clr_all = 1'b1; tick(); clr_all = 1'b0;
        check("R5", "cleared", 16'(ev_rdata), 16'h0);
        check("R8", "summary after clear", 16'(summary), 16'h0);
        check("R6", "mask kept", 16'(en_rdata), 16'h04);
        clr_all = 1'b1; evt_in = 8'h04; tick(); clr_all = 1'b0; evt_in = '0;
        check("R5", "collide keep", 16'(ev_rdata), 16'h04);
        check("R8", "collide summary", 16'(summary), 16'h1);
    endtask

    task automatic t_wide();
        w_evt = 16'h8001; tick(); w_evt = '0;
        check("R9", "wide set", w_evrd, 16'h8001);
        check("R9", "wide summary off", 16'(w_sum), 16'h0);
        w_enwr = 1'b1; w_enwd = 16'h8000; tick(); w_enwr = 1'b0;
        check("R9", "wide summary bit15", 16'(w_sum), 16'h1);
        w_rd = 1'b1;
        #1 check("R9", "wide read", w_evrd, 16'h8001);
        tick(); w_rd = 1'b0;
        check("R9", "wide cleared", w_evrd, 16'h0);
        check("R9", "wide summary drop", 16'(w_sum), 16'h0);
    endtask

    initial begin
        repeat (3) tick();
        rst = 1'b0;
        tick();
        t_reset();
        t_sticky();
        t_enable();
        t_read_clear();
        t_collide();
        t_clear();
        t_wide();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5 * 20000);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule